// File: doc/BRIEF.md
# I2C Master Byte-Count Transfer Controller

This block runs the data phase of an I2C master transfer once the bit engine has sent the address. It loads a programmed byte count and counts down one on each byte-done pulse. When the count runs out it ends the chunk in one of three ways. It can issue a STOP command. It can hold SCL low with a transfer-complete flag until software asks for a repeated START or a STOP. Or, in reload mode, it can hold SCL low with a reload flag until software writes a fresh count. For a multi-chunk transfer, software picks one of these three endings for every chunk.

The block also tells the bit engine whether to ACK or NACK each received byte. It keeps a running CRC-8 over the data bytes (polynomial x^8+x^2+x+1, zero start value, MSB first). When a checksum byte is requested, the last counted byte carries that checksum. The bit engine sends it when transmitting. When receiving, the block compares the incoming byte with the running CRC.

The controller has five states, held in `bcc_state_e`:
- **IDLE**: waiting for the end of the address phase.
- **XFER**: counting data bytes.
- **HOLD_TC**: software-end stretch.
- **HOLD_TCR**: reload stretch.
- **ENDING**: a STOP has been commanded and the block waits for the bus to report it.

The transitions are:
- IDLE→XFER when the address ends with a nonzero count.
- IDLE→HOLD_TC, IDLE→HOLD_TCR or IDLE→ENDING when the address ends with a zero count.
- XFER→HOLD_TCR on expiry with reload set.
- XFER→ENDING on expiry with auto-end set, or on a pending STOP.
- XFER→HOLD_TC on expiry otherwise.
- HOLD_TC→IDLE on a START request, which issues a repeated START.
- HOLD_TC→ENDING and HOLD_TCR→ENDING on a STOP request.
- HOLD_TCR→XFER on a nonzero count write.
- ENDING→IDLE when a STOP is seen on the bus.
- Any state→IDLE when the block is disabled.

Top module: `bytecnt_ctrl`

## Requirements
- R1: With reload off and auto-end on, `cmd_stop` pulses for one cycle in the cycle after the byte-done pulse that brings the count to zero.
- R2: With reload off and auto-end off, count expiry raises `tc` and `stretch`. Both stay high, whatever the other inputs do, until a START or STOP request arrives.
- R3: With reload on, count expiry raises `tcr` and `stretch`, whatever auto-end is set to. A START request is ignored in this state. A count write of zero is ignored. A nonzero count write loads that count, clears `tcr` and resumes counting.
- R4: A START request while `tc` is high pulses `cmd_rstart` in the next cycle, drops `tc` and `stretch`, and returns the block to waiting for an address phase.
- R5: A STOP request is stored. It produces `cmd_stop` after the byte in progress completes, or in the next cycle if SCL is being stretched. The stored request is cleared only by `stop_seen` or by disable.
- R6: In receive mode (`cfg_rx`=1), `nack` is 1 while the last byte before a STOP or repeated START is expected: a count of one remaining with reload off, or a stored STOP request. In every other case `nack` is 0, including the last byte of a reload chunk.
- R7: `pec_value` is the CRC-8 (polynomial 0x07, start value 0, MSB first) of every data byte since the latest address phase ended. It carries across reload chunks and excludes the checksum byte.
- R8: With a checksum requested and reload off, `pec_phase` is 1 while the final counted byte is expected. A checksum request has no effect while reload is set. The request is cleared by the checksum byte, `stop_seen`, `addr_match` or disable.
- R9: In receive mode, a checksum byte that differs from `pec_value` sets `pec_fail`. The flag clears at the next address-phase end.
- R10: A count of zero at address-phase end ends the transfer at once: a STOP if auto-end is set, otherwise `tc`, or `tcr` if reload is set.
- R11: Dropping `enable` returns all outputs and stored requests to zero at the next clock edge.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low clears everything |
| cfg_count | input | 8 | Programmed byte count |
| cfg_reload | input | 1 | Reload mode select |
| cfg_autoend | input | 1 | Automatic STOP on expiry |
| cfg_rx | input | 1 | 1 = master receives data |
| addr_done | input | 1 | Pulse: address phase finished |
| count_wr | input | 1 | Pulse: software wrote `cfg_count` |
| start_req | input | 1 | Pulse: software START request |
| stop_req | input | 1 | Pulse: software STOP request |
| pec_req | input | 1 | Pulse: software checksum request |
| byte_done | input | 1 | Pulse: bit engine finished a byte |
| byte_data | input | 8 | Byte just sent or received |
| stop_seen | input | 1 | Pulse: STOP detected on the bus |
| addr_match | input | 1 | Pulse: own address matched |
| tc | output | 1 | Transfer-complete flag |
| tcr | output | 1 | Reload-complete flag |
| stretch | output | 1 | Request to hold SCL low |
| cmd_stop | output | 1 | Pulse: generate STOP |
| cmd_rstart | output | 1 | Pulse: generate repeated START |
| nack | output | 1 | ACK value for the next received byte |
| pec_phase | output | 1 | Next counted byte is the checksum |
| pec_value | output | 8 | Running CRC-8 |
| pec_fail | output | 1 | Received checksum mismatch |

## Verification
Every flag and command is registered. `tc`, `tcr`, `stretch`, `cmd_stop`, `cmd_rstart`, `pec_value` and `pec_fail` therefore change at the first rising edge that samples the stimulus, and `cmd_stop` and `cmd_rstart` stay high for exactly that one cycle. `nack` and `pec_phase` are combinational from that registered state and from the mode inputs, so they are valid in the same cycle.

The bench drives its inputs just after the falling edge. A behavioural model advances at each rising edge. All outputs are compared at the next falling edge, so every result is sampled one edge after its stimulus. Directed checks at the same points cover the stretch holds, the ignored START and zero count, the checksum value and the disable.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_HOLD_TC,
        ST_HOLD_TCR,
        ST_ENDING
    } bcc_state_e;

endpackage

// File: rtl/bcc_counter.sv
// Down-counter for bytes left in the current chunk.
module bcc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] rem,
    output logic         last
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (clr) begin
            rem <= '0;
        end else if (load) begin
            rem <= load_val;
        end else if (dec && rem != '0) begin
            rem <= rem - ONE;
        end
    end

    assign last = (rem == ONE);

endmodule

// File: rtl/bcc_pec.sv
// Running CRC over data bytes, MSB first, one byte per update.
module bcc_pec #(
    parameter int           W    = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic [W-1:0] din,
    output logic [W-1:0] crc
);

    logic [W-1:0] chain [0:W];

    assign chain[0] = crc;

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic fb;
        assign fb = chain[g][W-1] ^ din[W-1-g];
        assign chain[g+1] = {chain[g][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (upd) begin
            crc <= chain[W];
        end
    end

endmodule

// File: rtl/bytecnt_ctrl.sv
module bytecnt_ctrl
    import bcc_pkg::*;
#(
    parameter int                 COUNT_W = 8,
    parameter int                 DATA_W  = 8,
    parameter logic [DATA_W-1:0]  PEC_POLY = 8'h07
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [COUNT_W-1:0] cfg_count,
    input  logic               cfg_reload,
    input  logic               cfg_autoend,
    input  logic               cfg_rx,
    input  logic               addr_done,
    input  logic               count_wr,
    input  logic               start_req,
    input  logic               stop_req,
    input  logic               pec_req,
    input  logic               byte_done,
    input  logic [DATA_W-1:0]  byte_data,
    input  logic               stop_seen,
    input  logic               addr_match,
    output logic               tc,
    output logic               tcr,
    output logic               stretch,
    output logic               cmd_stop,
    output logic               cmd_rstart,
    output logic               nack,
    output logic               pec_phase,
    output logic [DATA_W-1:0]  pec_value,
    output logic               pec_fail
);

    localparam logic [COUNT_W-1:0] ZERO_CNT = '0;

    bcc_state_e state, state_d;
    logic cmd_stop_d, cmd_rstart_d;
    logic stop_pend, pec_pend;
    logic stop_now, pec_byte, byte_ev, start_xfer;
    logic cnt_load, cnt_dec, cnt_last;
    logic [COUNT_W-1:0] cnt_rem;
    logic crc_clr, crc_upd;

    assign stop_now   = stop_pend | stop_req;
    assign pec_byte   = (state == ST_XFER) && pec_pend && !cfg_reload && cnt_last;
    assign byte_ev    = (state == ST_XFER) && byte_done;
    assign start_xfer = (state == ST_IDLE) && addr_done;

    bcc_counter #(.W(COUNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!enable),
        .load     (cnt_load),
        .dec      (cnt_dec),
        .load_val (cfg_count),
        .rem      (cnt_rem),
        .last     (cnt_last)
    );

    bcc_pec #(.W(DATA_W), .POLY(PEC_POLY)) u_pec (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .upd   (crc_upd),
        .din   (byte_data),
        .crc   (pec_value)
    );

    assign crc_clr  = !enable || start_xfer;
    assign crc_upd  = byte_ev && !pec_byte;
    assign cnt_dec  = byte_ev;
    assign cnt_load = start_xfer ||
                      ((state == ST_HOLD_TCR) && count_wr && cfg_count != ZERO_CNT && !stop_now);

    // Next-state and command decode
    always_comb begin
        state_d      = state;
        cmd_stop_d   = 1'b0;
        cmd_rstart_d = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (addr_done) begin
                    if (cfg_count != ZERO_CNT)  state_d = ST_XFER;
                    else if (cfg_reload)        state_d = ST_HOLD_TCR;
                    else if (cfg_autoend) begin
                        state_d    = ST_ENDING;
                        cmd_stop_d = 1'b1;
                    end else                    state_d = ST_HOLD_TC;
                end
            end
            ST_XFER: begin
                if (byte_done) begin
                    if (cnt_last && cfg_reload) begin
                        state_d = ST_HOLD_TCR;
                    end else if ((cnt_last && cfg_autoend) || stop_now) begin
                        state_d    = ST_ENDING;
                        cmd_stop_d = 1'b1;
                    end else if (cnt_last) begin
                        state_d = ST_HOLD_TC;
                    end
                end
            end
            ST_HOLD_TC: begin
                if (stop_now) begin
                    state_d    = ST_ENDING;
                    cmd_stop_d = 1'b1;
                end else if (start_req) begin
                    state_d      = ST_IDLE;
                    cmd_rstart_d = 1'b1;
                end
            end
            ST_HOLD_TCR: begin
                if (stop_now) begin
                    state_d    = ST_ENDING;
                    cmd_stop_d = 1'b1;
                end else if (count_wr && cfg_count != ZERO_CNT) begin
                    state_d = ST_XFER;
                end
            end
            ST_ENDING: begin
                if (stop_seen) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (!enable) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Registered outputs and stored requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_stop   <= 1'b0;
            cmd_rstart <= 1'b0;
            stop_pend  <= 1'b0;
            pec_pend   <= 1'b0;
            pec_fail   <= 1'b0;
        end else if (!enable) begin
            cmd_stop   <= 1'b0;
            cmd_rstart <= 1'b0;
            stop_pend  <= 1'b0;
            pec_pend   <= 1'b0;
            pec_fail   <= 1'b0;
        end else begin
            cmd_stop   <= cmd_stop_d;
            cmd_rstart <= cmd_rstart_d;
            if (stop_seen)     stop_pend <= 1'b0;
            else if (stop_req) stop_pend <= 1'b1;
            if (stop_seen || addr_match || (pec_byte && byte_done)) pec_pend <= 1'b0;
            else if (pec_req)                                      pec_pend <= 1'b1;
            if (start_xfer)
                pec_fail <= 1'b0;
            else if (pec_byte && byte_done && cfg_rx && byte_data != pec_value)
                pec_fail <= 1'b1;
        end
    end

    assign tc        = (state == ST_HOLD_TC);
    assign tcr       = (state == ST_HOLD_TCR);
    assign stretch   = tc | tcr;
    assign pec_phase = pec_byte;
    assign nack      = cfg_rx && (state == ST_XFER) &&
                       ((cnt_last && !cfg_reload) || stop_pend);

    // ---------------- assertions ----------------
    p_xfer_count_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER) |-> (cnt_rem != ZERO_CNT));

    p_auto_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_XFER && byte_done && cnt_last && !cfg_reload && cfg_autoend)
        |=> cmd_stop);

    p_tc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_HOLD_TC && !start_req && !stop_now) |=> tc);

    p_tcr_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_HOLD_TCR && start_req && !stop_now && !count_wr)
        |=> (tcr && !cmd_rstart));

    p_rstart_from_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rstart |-> ($past(state) == ST_HOLD_TC));

    p_cmd_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_stop && cmd_rstart));

    p_pec_consumed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pec_byte && byte_done) |=> !pec_pend);

    p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!stretch && !cmd_stop && !cmd_rstart && !pec_fail));

endmodule

// File: tb/bytecnt_ctrl_test.sv
module bytecnt_ctrl_test;

    localparam int TCLK = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic [7:0] cfg_count = 8'd0;
    logic       cfg_reload = 1'b0, cfg_autoend = 1'b0, cfg_rx = 1'b0;
    logic       addr_done = 1'b0, count_wr = 1'b0, start_req = 1'b0, stop_req = 1'b0;
    logic       pec_req = 1'b0, byte_done = 1'b0, stop_seen = 1'b0, addr_match = 1'b0;
    logic [7:0] byte_data = 8'd0;
    logic       tc, tcr, stretch, cmd_stop, cmd_rstart, nack, pec_phase, pec_fail;
    logic [7:0] pec_value;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(TCLK/2) clk = ~clk;

    bytecnt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_count(cfg_count),
        .cfg_reload(cfg_reload), .cfg_autoend(cfg_autoend), .cfg_rx(cfg_rx),
        .addr_done(addr_done), .count_wr(count_wr), .start_req(start_req),
        .stop_req(stop_req), .pec_req(pec_req), .byte_done(byte_done),
        .byte_data(byte_data), .stop_seen(stop_seen), .addr_match(addr_match),
        .tc(tc), .tcr(tcr), .stretch(stretch), .cmd_stop(cmd_stop),
        .cmd_rstart(cmd_rstart), .nack(nack), .pec_phase(pec_phase),
        .pec_value(pec_value), .pec_fail(pec_fail)
    );

    // CRC-8, poly 0x07: fold the byte in first, then shift eight times
    function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] x;
        x = c ^ d;
        for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction

    // ---------------- behavioural reference ----------------
    // m_st: 0 idle, 1 counting, 2 software-end hold, 3 reload hold, 4 waiting for stop
    int         m_st = 0;
    int         m_rem = 0;
    bit         m_stopp = 0, m_pecp = 0, m_fail = 0, m_cs = 0, m_cr = 0;
    logic [7:0] m_crc = 8'd0;

    always @(posedge clk) begin
        int  st, rem;
        bit  stopp, pecp, fail, cs, cr, pb, sn;
        logic [7:0] crc;
        if (!rst_n || !enable) begin
            m_st = 0; m_rem = 0; m_stopp = 0; m_pecp = 0; m_fail = 0;
            m_cs = 0; m_cr = 0; m_crc = 8'd0;
        end else begin
            st = m_st; rem = m_rem; stopp = m_stopp; pecp = m_pecp;
            fail = m_fail; crc = m_crc; cs = 0; cr = 0;
            pb = (m_st == 1) && m_pecp && !cfg_reload && (m_rem == 1);
            sn = m_stopp || stop_req;
            case (m_st)
                0: if (addr_done) begin
                    crc = 8'd0; fail = 0; rem = cfg_count;
                    if (cfg_count != 0) st = 1;
                    else if (cfg_reload) st = 3;
                    else if (cfg_autoend) begin st = 4; cs = 1; end
                    else st = 2;
                end
                1: if (byte_done) begin
                    if (pb) begin
                        if (cfg_rx && byte_data != m_crc) fail = 1;
                    end else crc = crc_byte(m_crc, byte_data);
                    rem = m_rem - 1;
                    if (m_rem == 1 && cfg_reload) st = 3;
                    else if ((m_rem == 1 && cfg_autoend) || sn) begin st = 4; cs = 1; end
                    else if (m_rem == 1) st = 2;
                end
                2: if (sn) begin st = 4; cs = 1; end
                   else if (start_req) begin st = 0; cr = 1; end
                3: if (sn) begin st = 4; cs = 1; end
                   else if (count_wr && cfg_count != 0) begin st = 1; rem = cfg_count; end
                4: if (stop_seen) st = 0;
                default: st = 0;
            endcase
            if (stop_seen) stopp = 0; else if (stop_req) stopp = 1;
            if (stop_seen || addr_match || (pb && byte_done)) pecp = 0;
            else if (pec_req) pecp = 1;
            m_st = st; m_rem = rem; m_stopp = stopp; m_pecp = pecp;
            m_fail = fail; m_crc = crc; m_cs = cs; m_cr = cr;
        end
    end

    task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output on every falling edge, before inputs move
    always @(negedge clk) begin
        if (rst_n) begin
            cmp("R2", "tc", {7'd0, tc}, {7'd0, m_st == 2});
            cmp("R3", "tcr", {7'd0, tcr}, {7'd0, m_st == 3});
            cmp("R2", "stretch", {7'd0, stretch}, {7'd0, m_st == 2 || m_st == 3});
            cmp("R1", "cmd_stop", {7'd0, cmd_stop}, {7'd0, m_cs});
            cmp("R4", "cmd_rstart", {7'd0, cmd_rstart}, {7'd0, m_cr});
            cmp("R6", "nack", {7'd0, nack},
                {7'd0, cfg_rx && m_st == 1 && ((m_rem == 1 && !cfg_reload) || m_stopp)});
            cmp("R8", "pec_phase", {7'd0, pec_phase},
                {7'd0, m_st == 1 && m_pecp && !cfg_reload && m_rem == 1});
            cmp("R7", "pec_value", pec_value, m_crc);
            cmp("R9", "pec_fail", {7'd0, pec_fail}, {7'd0, m_fail});
        end
    end

    task automatic cyc();
        @(negedge clk);
        #1;
        addr_done = 0; count_wr = 0; start_req = 0; stop_req = 0;
        pec_req = 0; byte_done = 0; stop_seen = 0; addr_match = 0;
    endtask

    task automatic send(input logic [7:0] d);
        byte_done = 1; byte_data = d; cyc();
    endtask

    task automatic setup(input int n, input bit rl, input bit ae, input bit rx);
        cfg_count = 8'(n); cfg_reload = rl; cfg_autoend = ae; cfg_rx = rx;
    endtask

    task automatic finish_stop();
        stop_seen = 1; cyc(); cyc();
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] ref_crc;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        cyc();
        // R12: outputs after reset
        cmp("R12", "reset outputs", {tc, tcr, stretch, cmd_stop, cmd_rstart, nack, pec_phase, pec_fail},
            8'd0);

        // R1: auto-end transmit of three bytes
        setup(3, 0, 1, 0); addr_done = 1; cyc();
        send(8'h11); send(8'h22);
        cmp("R1", "no stop before expiry", {7'd0, cmd_stop}, 8'd0);
        send(8'h33);
        cmp("R1", "stop at expiry", {7'd0, cmd_stop}, 8'd1);
        cyc();
        cmp("R1", "stop is one pulse", {7'd0, cmd_stop}, 8'd0);
        finish_stop();

        // R2, R4, R6: software end, receive two bytes then repeated START
        setup(2, 0, 0, 1); addr_done = 1; cyc();
        cmp("R6", "ack on first rx byte", {7'd0, nack}, 8'd0);
        send(8'hA5);
        cmp("R6", "nack on last rx byte", {7'd0, nack}, 8'd1);
        send(8'h5A);
        cmp("R2", "tc and stretch", {6'd0, tc, stretch}, 8'd3);
        for (int i = 0; i < 4; i++) begin
            byte_done = 1; cyc();
        end
        cmp("R2", "stretch held", {6'd0, tc, stretch}, 8'd3);
        start_req = 1; cyc();
        cmp("R4", "repeated start", {5'd0, cmd_rstart, tc, stretch}, 8'd4);
        cyc();

        // R3: reload chunks, ignored START and zero count
        setup(2, 1, 1, 1); addr_done = 1; cyc();
        send(8'h01);
        cmp("R6", "ack on reload last byte", {7'd0, nack}, 8'd0);
        send(8'h02);
        cmp("R3", "tcr despite auto-end", {5'd0, tcr, stretch, cmd_stop}, 8'd6);
        start_req = 1; cyc();
        cmp("R3", "start ignored in reload", {6'd0, tcr, cmd_rstart}, 8'd2);
        cfg_count = 0; count_wr = 1; cyc();
        cmp("R3", "zero count ignored", {7'd0, tcr}, 8'd1);
        cfg_count = 3; count_wr = 1; cyc();
        cmp("R3", "nonzero count resumes", {7'd0, tcr}, 8'd0);
        send(8'h03); send(8'h04); send(8'h05);
        ref_crc = crc_byte(crc_byte(crc_byte(crc_byte(crc_byte(8'h00, 8'h01), 8'h02), 8'h03), 8'h04), 8'h05);
        cmp("R7", "crc across chunks", pec_value, ref_crc);
        cfg_reload = 0; stop_req = 1; cyc();
        cmp("R5", "stop from stretch", {6'd0, cmd_stop, stretch}, 8'd2);
        finish_stop();

        // R7, R8: checksum appended on transmit
        pec_req = 1; cyc();
        setup(4, 0, 1, 0); addr_done = 1; cyc();
        send(8'hC3); send(8'h3C); send(8'h7E);
        ref_crc = crc_byte(crc_byte(crc_byte(8'h00, 8'hC3), 8'h3C), 8'h7E);
        cmp("R8", "pec phase on final byte", {7'd0, pec_phase}, 8'd1);
        cmp("R7", "pec value", pec_value, ref_crc);
        send(ref_crc);
        cmp("R8", "pec byte ends transfer", {6'd0, cmd_stop, pec_phase}, 8'd2);
        cmp("R7", "pec byte not folded in", pec_value, ref_crc);
        finish_stop();

        // R9: received checksum mismatch
        pec_req = 1; cyc();
        setup(3, 0, 0, 1); addr_done = 1; cyc();
        send(8'h10); send(8'h20);
        send(8'hFF);
        cmp("R9", "mismatch flagged", {6'd0, pec_fail, tc}, 8'd3);
        stop_req = 1; cyc();
        finish_stop();
        pec_req = 1; cyc();
        setup(2, 0, 1, 1); addr_done = 1; cyc();
        cmp("R9", "flag cleared at address end", {7'd0, pec_fail}, 8'd0);
        send(8'h42);
        send(crc_byte(8'h00, 8'h42));
        cmp("R9", "match not flagged", {7'd0, pec_fail}, 8'd0);
        finish_stop();

        // R8: checksum request ignored under reload, cleared by addr_match
        pec_req = 1; cyc();
        setup(1, 1, 0, 0); addr_done = 1; cyc();
        cmp("R8", "no pec phase with reload", {7'd0, pec_phase}, 8'd0);
        send(8'h99);
        addr_match = 1; cyc();
        cfg_reload = 0; cfg_count = 1; count_wr = 1; cyc();
        cmp("R8", "request cleared by addr match", {7'd0, pec_phase}, 8'd0);
        send(8'h98);
        stop_req = 1; cyc();
        finish_stop();

        // R10: zero counts
        setup(0, 0, 1, 0); addr_done = 1; cyc();
        cmp("R10", "zero count auto stop", {7'd0, cmd_stop}, 8'd1);
        finish_stop();
        setup(0, 0, 0, 0); addr_done = 1; cyc();
        cmp("R10", "zero count software end", {7'd0, tc}, 8'd1);
        stop_req = 1; cyc();
        finish_stop();
        setup(0, 1, 0, 0); addr_done = 1; cyc();
        cmp("R10", "zero count reload", {7'd0, tcr}, 8'd1);
        stop_req = 1; cyc();
        finish_stop();

        // R5: STOP request waits for the byte in progress
        setup(5, 0, 0, 1); addr_done = 1; cyc();
        stop_req = 1; cyc();
        cmp("R5", "stop held until byte ends", {6'd0, cmd_stop, nack}, 8'd1);
        send(8'h77);
        cmp("R5", "stop after byte", {7'd0, cmd_stop}, 8'd1);
        cyc(); cyc();
        finish_stop();

        // R11: disable mid-transfer
        pec_req = 1; cyc();
        setup(2, 0, 0, 0); addr_done = 1; cyc();
        send(8'h12); send(8'h34);
        enable = 0; cyc();
        cmp("R11", "disable clears", {tc, tcr, stretch, cmd_stop, cmd_rstart, nack, pec_phase, pec_fail},
            8'd0);
        cmp("R11", "disable clears crc", pec_value, 8'd0);
        enable = 1; cyc();
        setup(1, 0, 0, 0); addr_done = 1; cyc();
        cmp("R11", "checksum request dropped", {7'd0, pec_phase}, 8'd0);
        send(8'h01);
        stop_req = 1; cyc();
        finish_stop();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule